// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block opens the configuration space of a multi-function peripheral chip through two neighbouring byte addresses on a plain 8-bit I/O bus. The lower address is the index port and the address one above it is the data port. After reset the port is closed. It opens only when the opening key byte is written twice in a row to the index port. A separate closing key written to the same address shuts it again.

While the port is open, an index-port write picks a register number, and data-port accesses then reach that register. Two registers live inside the block. One is a logical-device selector. The other is a fixed identification byte that can only be read. Every other register number is passed to the register banks of the logical devices. The block drives the selected device number, the register number, the write data and one-cycle read and write strobes, and it flags whether the register is banked per device or global.

Top module: `cfg_keyport`

## Requirements
- R1: After reset the port is closed (`unlocked` = 0), the device selector reads 0, and `dev_wr` and `dev_rd` are low.
- R2: Two back-to-back index-port writes of 0x87 open the port, and `unlocked` is 1 from the clock edge that takes the second write.
- R3: While closed, any index-port write other than 0x87 clears a partial key. The sequence 0x87, another value, 0x87 leaves the port closed.
- R4: While open, an index-port write of 0xAA closes the port at that edge. Data-port reads return 0xFF afterwards.
- R5: While closed, data-port writes have no effect: there is no `dev_wr` and the selector does not change. Reads of either port return 0xFF and raise no `dev_rd`.
- R6: While open, an index-port write other than 0xAA stores the register number, and a read of the index port returns it.
- R7: Register 0x07 holds the logical-device selector. A data write sets it and drives `dev_sel` from the next cycle, a data read returns it, and neither access strobes the device side.
- R8: Register 0x20 reads the constant CHIP_ID (default 0x52). Writes to it are dropped without a strobe.
- R9: For any other register, a data write raises `dev_wr` for that cycle with `dev_index` equal to the register number and `dev_wdata` equal to the bus data. A data read raises `dev_rd` and returns `dev_rdata`.
- R10: `dev_banked` is 1 when the current register number is 0x30 or above, and 0 below it.
- R11: Bus accesses to any address other than the two port addresses change nothing and read 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | Bus address |
| io_wr | input | 1 | Bus write strobe, one cycle per access |
| io_rd | input | 1 | Bus read strobe (a write in the same cycle takes precedence) |
| io_wdata | input | 8 | Bus write data |
| io_rdata | output | 8 | Bus read data, valid during the read cycle |
| unlocked | output | 1 | Configuration port is open |
| dev_sel | output | 8 | Selected logical device |
| dev_index | output | 8 | Current register number |
| dev_banked | output | 1 | Register number is in the per-device range |
| dev_wr | output | 1 | Device register write strobe |
| dev_wdata | output | 8 | Device register write data |
| dev_rd | output | 1 | Device register read strobe |
| dev_rdata | input | 8 | Read data from the selected device register |

## Verification
The assertions watch on every cycle that a closed port raises no device strobe and reads back 0xFF. They also check that the port opens only at an edge that took the opening key, that the closing key always shuts it, and that the selector stays put unless a data write reaches it. Only the bench scenarios can show that a broken key sequence is forgotten, that the identification byte and the stored index read back correctly, and that forwarded accesses carry the right device, register and data. The same holds for the banked/global split and for ignoring stray addresses.

// File: rtl/cfg_keyport_pkg.sv
package cfg_keyport_pkg;

    typedef enum logic [1:0] {
        LK_SHUT = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_e;

    typedef enum logic [1:0] {
        RK_SELECT = 2'd0,
        RK_IDENT  = 2'd1,
        RK_GLOBAL = 2'd2,
        RK_BANKED = 2'd3
    } regkind_e;

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] sel;
    } port_state_t;

endpackage

// File: rtl/cfg_keyport_lock.sv
module cfg_keyport_lock
    import cfg_keyport_pkg::*;
#(
    parameter logic [7:0] KEY_OPEN  = 8'h87,
    parameter logic [7:0] KEY_CLOSE = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    output logic       is_open
);

    lock_e lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (key_wr) begin
            unique case (lock_q)
                LK_SHUT: lock_d = (key_data == KEY_OPEN) ? LK_HALF : LK_SHUT;
                LK_HALF: lock_d = (key_data == KEY_OPEN) ? LK_OPEN : LK_SHUT;
                LK_OPEN: lock_d = (key_data == KEY_CLOSE) ? LK_SHUT : LK_OPEN;
                default: lock_d = LK_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= LK_SHUT;
        else        lock_q <= lock_d;
    end

    assign is_open = (lock_q == LK_OPEN);

endmodule

// File: rtl/cfg_keyport_decode.sv
module cfg_keyport_decode
    import cfg_keyport_pkg::*;
#(
    parameter logic [7:0] SEL_REG    = 8'h07,
    parameter logic [7:0] ID_REG     = 8'h20,
    parameter logic [7:0] BANK_START = 8'h30
) (
    input  logic [7:0] index,
    output regkind_e   kind,
    output logic       banked
);

    always_comb begin
        banked = (index >= BANK_START);
        if (index == SEL_REG)      kind = RK_SELECT;
        else if (index == ID_REG)  kind = RK_IDENT;
        else if (banked)           kind = RK_BANKED;
        else                       kind = RK_GLOBAL;
    end

endmodule

// File: rtl/cfg_keyport.sv
module cfg_keyport
    import cfg_keyport_pkg::*;
#(
    parameter int         ADDR_W     = 16,
    parameter int         BASE_ADDR  = 'h2E,
    parameter logic [7:0] KEY_OPEN   = 8'h87,
    parameter logic [7:0] KEY_CLOSE  = 8'hAA,
    parameter logic [7:0] SEL_REG    = 8'h07,
    parameter logic [7:0] ID_REG     = 8'h20,
    parameter logic [7:0] BANK_START = 8'h30,
    parameter logic [7:0] CHIP_ID    = 8'h52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              unlocked,
    output logic [7:0]        dev_sel,
    output logic [7:0]        dev_index,
    output logic              dev_banked,
    output logic              dev_wr,
    output logic [7:0]        dev_wdata,
    output logic              dev_rd,
    input  logic [7:0]        dev_rdata
);

    localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE_ADDR + 1);
    localparam logic [7:0]        IDLE_RD  = 8'hFF;

    port_state_t st_d, st_q;
    regkind_e    kind;
    logic        is_open;
    logic        hit_idx, hit_dat;
    logic        idx_wr, dat_wr, dat_rd;
    logic        to_dev;

    assign hit_idx = (io_addr == IDX_ADDR);
    assign hit_dat = (io_addr == DAT_ADDR);
    assign idx_wr  = io_wr & hit_idx;

    cfg_keyport_lock #(
        .KEY_OPEN (KEY_OPEN),
        .KEY_CLOSE(KEY_CLOSE)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (idx_wr),
        .key_data(io_wdata),
        .is_open (is_open)
    );

    cfg_keyport_decode #(
        .SEL_REG   (SEL_REG),
        .ID_REG    (ID_REG),
        .BANK_START(BANK_START)
    ) u_decode (
        .index (st_q.index),
        .kind  (kind),
        .banked(dev_banked)
    );

    assign dat_wr = io_wr & hit_dat & is_open;
    assign dat_rd = io_rd & ~io_wr & hit_dat & is_open;
    assign to_dev = (kind == RK_GLOBAL) || (kind == RK_BANKED);

    always_comb begin
        st_d = st_q;
        if (idx_wr && is_open && (io_wdata != KEY_CLOSE))
            st_d.index = io_wdata;
        if (dat_wr && (kind == RK_SELECT))
            st_d.sel = io_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        io_rdata = IDLE_RD;
        if (io_rd && !io_wr && is_open) begin
            if (hit_idx) begin
                io_rdata = st_q.index;
            end else if (hit_dat) begin
                unique case (kind)
                    RK_SELECT: io_rdata = st_q.sel;
                    RK_IDENT:  io_rdata = CHIP_ID;
                    default:   io_rdata = dev_rdata;
                endcase
            end
        end
    end

    assign unlocked  = is_open;
    assign dev_sel   = st_q.sel;
    assign dev_index = st_q.index;
    assign dev_wdata = io_wdata;
    assign dev_wr    = dat_wr & to_dev;
    assign dev_rd    = dat_rd & to_dev;

endmodule

// File: rtl/cfg_keyport_chk.sv
module cfg_keyport_chk #(
    parameter int         ADDR_W    = 16,
    parameter int         BASE_ADDR = 'h2E,
    parameter logic [7:0] KEY_OPEN  = 8'h87,
    parameter logic [7:0] KEY_CLOSE = 8'hAA,
    parameter logic [7:0] ID_REG    = 8'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              unlocked,
    input logic [7:0]        dev_sel,
    input logic [7:0]        dev_index,
    input logic              dev_wr,
    input logic              dev_rd
);

    localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE_ADDR + 1);

    AST_SHUT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> (!dev_wr && !dev_rd)); // R5

    AST_SHUT_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && io_rd) |-> (io_rdata == 8'hFF)); // R5

    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(io_wr && (io_addr == IDX_ADDR) && (io_wdata == KEY_OPEN))); // R2

    AST_CLOSE_KEY_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && io_wr && (io_addr == IDX_ADDR) && (io_wdata == KEY_CLOSE)) |=> !unlocked); // R4

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(unlocked && io_wr && (io_addr == DAT_ADDR)) |=> $stable(dev_sel)); // R7

    AST_ID_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_index == ID_REG) |-> !dev_wr); // R8

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_wr && dev_rd)); // R9

endmodule

bind cfg_keyport cfg_keyport_chk #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .KEY_OPEN (KEY_OPEN),
    .KEY_CLOSE(KEY_CLOSE),
    .ID_REG   (ID_REG)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .unlocked (unlocked),
    .dev_sel  (dev_sel),
    .dev_index(dev_index),
    .dev_wr   (dev_wr),
    .dev_rd   (dev_rd)
);

// File: tb/cfg_keyport_test.sv
module cfg_keyport_test;

    localparam int         AW   = 16;
    localparam logic [15:0] IDX = 16'h002E;
    localparam logic [15:0] DAT = 16'h002F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        unlocked;
    logic [7:0]  dev_sel, dev_index, dev_wdata, dev_rdata;
    logic        dev_banked, dev_wr, dev_rd;

    always #5 clk = ~clk;

    // bench-side peripheral: read data derived from selector and register number
    function automatic logic [7:0] periph(input logic [7:0] s, input logic [7:0] i);
        return s ^ {i[3:0], i[7:4]} ^ 8'h5A;
    endfunction
    assign dev_rdata = periph(dev_sel, dev_index);

    cfg_keyport #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .unlocked(unlocked),
        .dev_sel(dev_sel), .dev_index(dev_index), .dev_banked(dev_banked),
        .dev_wr(dev_wr), .dev_wdata(dev_wdata), .dev_rd(dev_rd), .dev_rdata(dev_rdata)
    );

    typedef struct {
        logic [7:0] data;
        logic       strobe;
        string      tag;
    } rd_item_t;

    typedef struct {
        logic [7:0] sel;
        logic [7:0] idx;
        logic [7:0] data;
        logic       banked;
        string      tag;
    } wr_item_t;

    rd_item_t rd_q[$];
    wr_item_t wr_q[$];
    int checks = 0;
    int fails  = 0;
    string quiet_tag = "R5";

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compares design results against queued expectations
    always @(negedge clk) begin
        if (rst_n && io_rd && !io_wr) begin
            if (rd_q.size() == 0) begin
                check(1'b0, "R5 unexpected read", io_rdata, 0);
            end else begin
                rd_item_t e;
                e = rd_q.pop_front();
                check(io_rdata == e.data, e.tag, io_rdata, e.data);
                check(dev_rd == e.strobe, {e.tag, " dev_rd"}, dev_rd, e.strobe);
            end
        end
        if (rst_n && dev_wr) begin
            if (wr_q.size() == 0) begin
                check(1'b0, {quiet_tag, " write leaked"}, dev_index, 0);
            end else begin
                wr_item_t w;
                w = wr_q.pop_front();
                check({dev_sel, dev_index, dev_wdata, dev_banked} ==
                      {w.sel, w.idx, w.data, w.banked}, w.tag,
                      {dev_sel, dev_index, dev_wdata, 7'd0, dev_banked},
                      {w.sel, w.idx, w.data, 7'd0, w.banked});
            end
        end
    end

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #2;
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic [7:0] exp, input logic strb,
                          input string tag);
        rd_item_t e;
        e.data = exp; e.strobe = strb; e.tag = tag;
        rd_q.push_back(e);
        io_addr = a; io_rd = 1'b1;
        @(posedge clk); #2;
        io_rd = 1'b0;
    endtask

    task automatic dev_write(input logic [7:0] s, input logic [7:0] i, input logic [7:0] d,
                             input string tag);
        wr_item_t w;
        w.sel = s; w.idx = i; w.data = d; w.banked = (i >= 8'h30); w.tag = tag;
        wr_q.push_back(w);
        bus_wr(DAT, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog R1", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;

        // R1 reset state
        check(unlocked == 1'b0, "R1 unlocked", unlocked, 0);
        check(dev_sel == 8'h00, "R1 dev_sel", dev_sel, 0);
        check(!dev_wr && !dev_rd, "R1 strobes", {dev_wr, dev_rd}, 0);

        // R5 closed port
        quiet_tag = "R5";
        bus_rd(DAT, 8'hFF, 1'b0, "R5 locked data read");
        bus_rd(IDX, 8'hFF, 1'b0, "R5 locked index read");
        bus_wr(DAT, 8'h33);
        check(dev_sel == 8'h00, "R5 selector untouched", dev_sel, 0);

        // R3 broken key
        bus_wr(IDX, 8'h87);
        bus_wr(IDX, 8'h11);
        bus_wr(IDX, 8'h87);
        check(unlocked == 1'b0, "R3 broken key stays locked", unlocked, 0);
        bus_wr(IDX, 8'h00);

        // R2 proper key
        bus_wr(IDX, 8'h87);
        check(unlocked == 1'b0, "R2 one key not enough", unlocked, 0);
        bus_wr(IDX, 8'h87);
        check(unlocked == 1'b1, "R2 unlocked", unlocked, 1);

        // R6 index storage
        bus_wr(IDX, 8'h07);
        bus_rd(IDX, 8'h07, 1'b0, "R6 index readback");

        // R7 selector
        quiet_tag = "R7";
        bus_wr(DAT, 8'h08);
        check(dev_sel == 8'h08, "R7 dev_sel", dev_sel, 8'h08);
        bus_rd(DAT, 8'h08, 1'b0, "R7 selector read");

        // R8 identification
        quiet_tag = "R8";
        bus_wr(IDX, 8'h20);
        bus_rd(DAT, 8'h52, 1'b0, "R8 chip id");
        bus_wr(DAT, 8'h99);
        bus_rd(DAT, 8'h52, 1'b0, "R8 chip id after write");

        // R9 / R10 forwarding
        bus_wr(IDX, 8'h30);
        check(dev_banked == 1'b1, "R10 banked at 0x30", dev_banked, 1);
        dev_write(8'h08, 8'h30, 8'h5C, "R9 banked write");
        bus_rd(DAT, periph(8'h08, 8'h30), 1'b1, "R9 banked read");
        bus_wr(IDX, 8'h2F);
        check(dev_banked == 1'b0, "R10 global at 0x2F", dev_banked, 0);
        dev_write(8'h08, 8'h2F, 8'hA1, "R9 R10 global write");
        bus_rd(DAT, periph(8'h08, 8'h2F), 1'b1, "R9 global read");
        bus_wr(IDX, 8'h07);
        bus_wr(DAT, 8'h03);
        bus_wr(IDX, 8'hF6);
        dev_write(8'h03, 8'hF6, 8'h3C, "R9 R10 banked write dev3");
        bus_rd(DAT, periph(8'h03, 8'hF6), 1'b1, "R9 banked read dev3");

        // R11 stray address
        quiet_tag = "R11";
        bus_wr(16'h0030, 8'hAA);
        check(unlocked == 1'b1, "R11 stray write ignored", unlocked, 1);
        bus_rd(16'h0030, 8'hFF, 1'b0, "R11 stray read");
        bus_rd(IDX, 8'hF6, 1'b0, "R11 index unchanged");

        // R4 exit key
        bus_wr(IDX, 8'h07);
        bus_wr(IDX, 8'hAA);
        check(unlocked == 1'b0, "R4 exit key", unlocked, 0);
        bus_rd(DAT, 8'hFF, 1'b0, "R4 read after exit");
        quiet_tag = "R5";
        bus_wr(DAT, 8'h55);
        check(dev_sel == 8'h03, "R5 locked selector write ignored", dev_sel, 3);
        bus_wr(IDX, 8'h87);
        bus_wr(IDX, 8'h87);
        bus_rd(DAT, 8'h03, 1'b0, "R5 selector kept over relock");

        repeat (2) @(posedge clk); #2;
        check(rd_q.size() == 0, "R9 read queue drained", rd_q.size(), 0);
        check(wr_q.size() == 0, "R9 write queue drained", wr_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule